// File: doc/BRIEF.md
# RTU Register Request Parser

This block sits behind a serial receiver in a register-based slave and turns a binary RTU request into decoded command fields. Bytes arrive one per `rx_valid` cycle. A separate end-of-frame strobe, produced by whatever logic measures line silence, marks each frame boundary. The parser checks the first byte against the configured slave address and decodes one of three function codes: read registers (03h), write one register (06h) and write many registers (10h). It captures the register address and the word count. Write data is passed on as a stream of 16-bit words with an index.

A CRC-16 engine runs alongside the parser. It uses the reflected polynomial A001h and a seed of FFFFh, and it covers every byte from the address up to the last payload byte. The parser compares the engine's result with the two CRC bytes that close the frame, which arrive low byte first. A verified frame gives one `cmd_valid` cycle. A frame that fails gives exactly one of `func_err`, `len_err` or `crc_err`. A frame for another slave gives nothing. Write words are streamed before the CRC is known, so the consumer must stage them and commit only on `cmd_valid`.

Parser states:
- `ST_ADDR`: waits for the address byte. A match goes to `ST_FUNC`. A mismatch goes to `ST_SKIP`.
- `ST_FUNC`: a known code goes to `ST_REG_HI`. An unknown code goes to `ST_SKIP`.
- `ST_REG_HI` goes to `ST_REG_LO`.
- `ST_REG_LO`: goes to `ST_DAT_HI` for 06h and to `ST_CNT_HI` otherwise.
- `ST_CNT_HI` goes to `ST_CNT_LO`.
- `ST_CNT_LO`: an illegal count goes to `ST_SKIP`. Otherwise 03h goes to `ST_CRC_LO` and 10h goes to `ST_BCNT`.
- `ST_BCNT`: a mismatched byte count goes to `ST_SKIP`. Otherwise it goes to `ST_DAT_HI`.
- `ST_DAT_HI` goes to `ST_DAT_LO`.
- `ST_DAT_LO`: goes back to `ST_DAT_HI` until the last word, then to `ST_CRC_LO`.
- `ST_CRC_LO` goes to `ST_CRC_HI`.
- `ST_CRC_HI` goes to `ST_HOLD`.
- `ST_HOLD` and `ST_SKIP` stay where they are.

From any state, `frame_end` returns the parser to `ST_ADDR`.

Top module: `rtu_cmd_parser`

## Requirements
- R1: After reset, every pulse output and `addr_match` are low, and the parser waits for an address byte.
- R2: Address filtering.
  - If the first byte differs from `my_addr`, the frame produces no pulse of any kind and `addr_match` stays low.
  - If the first byte matches, `addr_match` rises in the cycle after that byte. It stays high until the cycle after `frame_end`.
- R3: Function codes 03h, 06h and 10h are accepted. Any other code raises `func_err` for one cycle, in the cycle after the function byte, and the rest of the frame is ignored.
- R4: Field order.
  - After the function code comes a 16-bit register address, high byte first. It is reported on `cmd_start`.
  - For 03h and 10h, a 16-bit word count follows, high byte first. It is reported on `cmd_count`.
  - For 06h, `cmd_count` reads 1.
  - `cmd_slave` and `cmd_func` report the first two bytes.
- R5: Write data stream.
  - Each write word is sent high byte first.
  - `wr_valid` pulses in the cycle after the word's low byte, with `wr_data` and `wr_idx` counting from 0.
  - 06h yields one word at index 0.
  - 10h yields the count's worth of words, in order.
- R6: Length checks.
  - A word count of 0, or a count above 32 for 10h, raises `len_err` in the cycle after the count's low byte.
  - For 10h, a byte count other than twice the word count raises `len_err` in the cycle after the byte count.
  - After either error the frame is ignored and no write words are emitted.
- R7: CRC check.
  - The CRC is CRC-16 with polynomial A001h (LSB first), seed FFFFh, taken over the address through the last payload byte.
  - It is received low byte first.
  - On a match, `cmd_valid` is high for exactly one cycle, the cycle after the CRC high byte.
  - On a mismatch, `crc_err` is high for that one cycle instead, and `cmd_valid` stays low.
- R8: Bytes after the CRC are ignored until `frame_end`.
  - `frame_end` at any point returns the parser to waiting for an address.
  - A truncated frame produces no pulse, and the next frame parses normally.
  - `frame_end` wins over a byte presented in the same cycle.
- R9: At most one of `cmd_valid`, `crc_err`, `len_err` and `func_err` is high in any cycle. Each is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_addr | input | 8 | Configured slave address |
| rx_valid | input | 1 | `rx_byte` holds a received byte this cycle |
| rx_byte | input | 8 | Received byte |
| frame_end | input | 1 | End-of-frame strobe |
| addr_match | output | 1 | Current frame is addressed to this slave |
| cmd_valid | output | 1 | CRC verified; command fields valid this cycle |
| cmd_slave | output | 8 | Address byte of the frame |
| cmd_func | output | 8 | Function code |
| cmd_start | output | 16 | Register start address |
| cmd_count | output | 16 | Word count (1 for single write) |
| wr_valid | output | 1 | Write word present on `wr_data` |
| wr_data | output | 16 | Write data word |
| wr_idx | output | 5 | Index of the write word within the frame |
| func_err | output | 1 | Unsupported function code |
| len_err | output | 1 | Illegal word count or byte count |
| crc_err | output | 1 | CRC mismatch |

## Verification
The bench goes after four length boundaries:
- a 10h write of exactly 32 words, which must pass;
- 33 words and a zero count, which must raise `len_err`;
- a byte count that disagrees with the word count;
- a zero-count read.

A parser with an off-by-one limit would reject the full 32-word write or accept 33. A parser that checked only one of the two counts would stream words from a malformed frame.

Further cases:
- A single corrupted CRC bit must turn `cmd_valid` into `crc_err`. An engine that absorbed the CRC bytes, or swapped their order, fails every frame.
- A frame cut short by `frame_end` must leave the next frame intact.
- Trailing bytes after a good CRC must stay silent.
- Frames for another address must produce nothing at all.

// File: rtl/rtu_pkg.sv
package rtu_pkg;

    typedef enum logic [3:0] {
        ST_ADDR,
        ST_FUNC,
        ST_REG_HI,
        ST_REG_LO,
        ST_CNT_HI,
        ST_CNT_LO,
        ST_BCNT,
        ST_DAT_HI,
        ST_DAT_LO,
        ST_CRC_LO,
        ST_CRC_HI,
        ST_HOLD,
        ST_SKIP
    } parse_st_t;

    localparam logic [7:0] FC_RD_MULTI = 8'h03;
    localparam logic [7:0] FC_WR_ONE   = 8'h06;
    localparam logic [7:0] FC_WR_MULTI = 8'h10;

    localparam logic [15:0] CRC_POLY = 16'hA001;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;

    function automatic logic fc_known(input logic [7:0] fc);
        return (fc == FC_RD_MULTI) || (fc == FC_WR_ONE) || (fc == FC_WR_MULTI);
    endfunction

endpackage

// File: rtl/rtu_crc16.sv
module rtu_crc16 #(
    parameter logic [15:0] POLY = 16'hA001,
    parameter logic [15:0] SEED = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);

    logic [15:0] nxt;

    // one byte per cycle, eight LSB-first shift steps unrolled
    always_comb begin
        nxt = crc ^ {8'h00, din};
        for (int b = 0; b < 8; b++) begin
            nxt = nxt[0] ? ((nxt >> 1) ^ POLY) : (nxt >> 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     crc <= SEED;
        else if (clear) crc <= SEED;
        else if (en)    crc <= nxt;
    end

endmodule

// File: rtl/rtu_len_check.sv
module rtu_len_check
    import rtu_pkg::*;
#(
    parameter int MAX_WORDS = 32
) (
    input  logic [7:0]  func,
    input  logic [7:0]  cnt_hi,
    input  logic [7:0]  cnt_lo,
    input  logic [15:0] cnt_full,
    input  logic [7:0]  bcnt,
    output logic        count_bad,
    output logic        bytes_bad
);

    logic [15:0] cnt_new;

    assign cnt_new   = {cnt_hi, cnt_lo};
    assign count_bad = (cnt_new == 16'd0) ||
                       ((func == FC_WR_MULTI) && (cnt_new > 16'(MAX_WORDS)));
    assign bytes_bad = ({cnt_full, 1'b0} != {9'd0, bcnt});

endmodule

// File: rtl/rtu_cmd_parser.sv
module rtu_cmd_parser
    import rtu_pkg::*;
#(
    parameter  int MAX_WORDS = 32,
    localparam int IDX_W     = $clog2(MAX_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        my_addr,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              frame_end,
    output logic              addr_match,
    output logic              cmd_valid,
    output logic [7:0]        cmd_slave,
    output logic [7:0]        cmd_func,
    output logic [15:0]       cmd_start,
    output logic [15:0]       cmd_count,
    output logic              wr_valid,
    output logic [15:0]       wr_data,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              func_err,
    output logic              len_err,
    output logic              crc_err
);

    localparam int PAD_W = 16 - IDX_W;

    parse_st_t         state_q, state_d;
    logic              take;
    logic              crc_en;
    logic [15:0]       crc_val;
    logic [7:0]        crc_lo_q;
    logic [7:0]        data_hi_q;
    logic [IDX_W-1:0]  data_idx_q;
    logic              count_bad, bytes_bad;
    logic              last_word;

    // frame_end takes priority over a byte in the same cycle
    assign take   = rx_valid && !frame_end;
    assign crc_en = take && (state_q inside {ST_ADDR, ST_FUNC, ST_REG_HI, ST_REG_LO,
                                             ST_CNT_HI, ST_CNT_LO, ST_BCNT,
                                             ST_DAT_HI, ST_DAT_LO});
    assign last_word = (cmd_func == FC_WR_ONE) ||
                       (({{PAD_W{1'b0}}, data_idx_q} + 16'd1) == cmd_count);

    rtu_crc16 #(.POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (frame_end),
        .en    (crc_en),
        .din   (rx_byte),
        .crc   (crc_val)
    );

    rtu_len_check #(.MAX_WORDS(MAX_WORDS)) u_len (
        .func      (cmd_func),
        .cnt_hi    (cmd_count[15:8]),
        .cnt_lo    (rx_byte),
        .cnt_full  (cmd_count),
        .bcnt      (rx_byte),
        .count_bad (count_bad),
        .bytes_bad (bytes_bad)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ADDR;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (frame_end) begin
            state_d = ST_ADDR;
        end else if (rx_valid) begin
            unique case (state_q)
                ST_ADDR:   state_d = (rx_byte == my_addr) ? ST_FUNC : ST_SKIP;
                ST_FUNC:   state_d = fc_known(rx_byte) ? ST_REG_HI : ST_SKIP;
                ST_REG_HI: state_d = ST_REG_LO;
                ST_REG_LO: state_d = (cmd_func == FC_WR_ONE) ? ST_DAT_HI : ST_CNT_HI;
                ST_CNT_HI: state_d = ST_CNT_LO;
                ST_CNT_LO: state_d = count_bad ? ST_SKIP :
                                     (cmd_func == FC_RD_MULTI) ? ST_CRC_LO : ST_BCNT;
                ST_BCNT:   state_d = bytes_bad ? ST_SKIP : ST_DAT_HI;
                ST_DAT_HI: state_d = ST_DAT_LO;
                ST_DAT_LO: state_d = last_word ? ST_CRC_LO : ST_DAT_HI;
                ST_CRC_LO: state_d = ST_CRC_HI;
                ST_CRC_HI: state_d = ST_HOLD;
                ST_HOLD:   state_d = ST_HOLD;
                ST_SKIP:   state_d = ST_SKIP;
                default:   state_d = ST_ADDR;
            endcase
        end
    end

    // outputs and field capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_match <= 1'b0;
            cmd_valid  <= 1'b0;
            cmd_slave  <= '0;
            cmd_func   <= '0;
            cmd_start  <= '0;
            cmd_count  <= '0;
            wr_valid   <= 1'b0;
            wr_data    <= '0;
            wr_idx     <= '0;
            func_err   <= 1'b0;
            len_err    <= 1'b0;
            crc_err    <= 1'b0;
            crc_lo_q   <= '0;
            data_hi_q  <= '0;
            data_idx_q <= '0;
        end else begin
            cmd_valid <= 1'b0;
            wr_valid  <= 1'b0;
            func_err  <= 1'b0;
            len_err   <= 1'b0;
            crc_err   <= 1'b0;
            if (frame_end) begin
                addr_match <= 1'b0;
            end else if (take) begin
                unique case (state_q)
                    ST_ADDR: begin
                        cmd_slave  <= rx_byte;
                        addr_match <= (rx_byte == my_addr);
                    end
                    ST_FUNC: begin
                        cmd_func <= rx_byte;
                        func_err <= !fc_known(rx_byte);
                    end
                    ST_REG_HI: cmd_start[15:8] <= rx_byte;
                    ST_REG_LO: begin
                        cmd_start[7:0] <= rx_byte;
                        data_idx_q     <= '0;
                        if (cmd_func == FC_WR_ONE) cmd_count <= 16'd1;
                    end
                    ST_CNT_HI: cmd_count[15:8] <= rx_byte;
                    ST_CNT_LO: begin
                        cmd_count[7:0] <= rx_byte;
                        len_err        <= count_bad;
                    end
                    ST_BCNT:   len_err   <= bytes_bad;
                    ST_DAT_HI: data_hi_q <= rx_byte;
                    ST_DAT_LO: begin
                        wr_valid   <= 1'b1;
                        wr_data    <= {data_hi_q, rx_byte};
                        wr_idx     <= data_idx_q;
                        data_idx_q <= data_idx_q + 1'b1;
                    end
                    ST_CRC_LO: crc_lo_q <= rx_byte;
                    ST_CRC_HI: begin
                        if ({rx_byte, crc_lo_q} == crc_val) cmd_valid <= 1'b1;
                        else                                crc_err   <= 1'b1;
                    end
                    ST_HOLD, ST_SKIP: ;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/rtu_cmd_parser_chk.sv
module rtu_cmd_parser_chk
    import rtu_pkg::*;
#(
    parameter int MAX_WORDS = 32,
    parameter int IDX_W     = $clog2(MAX_WORDS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_end,
    input logic              addr_match,
    input logic              cmd_valid,
    input logic [7:0]        cmd_func,
    input logic [15:0]       cmd_count,
    input logic              wr_valid,
    input logic [IDX_W-1:0]  wr_idx,
    input logic              func_err,
    input logic              len_err,
    input logic              crc_err
);

    p_quiet_mismatch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_match |-> !(cmd_valid || wr_valid || func_err || len_err || crc_err))
        else $error("R2: pulse seen without address match");

    p_single_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && cmd_func == FC_WR_ONE) |-> (wr_idx == '0))
        else $error("R5: single write word not at index 0");

    p_count_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_func == FC_WR_MULTI) |->
            (cmd_count != 16'd0 && cmd_count <= 16'(MAX_WORDS)))
        else $error("R6: accepted multi-write count out of range");

    p_cmd_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid)
        else $error("R7: cmd_valid longer than one cycle");

    p_frame_end_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !(addr_match || cmd_valid || wr_valid || func_err || len_err || crc_err))
        else $error("R8: outputs active after frame_end");

    p_outcome_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid, crc_err, len_err, func_err}))
        else $error("R9: more than one outcome pulse");

endmodule

bind rtu_cmd_parser rtu_cmd_parser_chk #(.MAX_WORDS(MAX_WORDS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_end  (frame_end),
    .addr_match (addr_match),
    .cmd_valid  (cmd_valid),
    .cmd_func   (cmd_func),
    .cmd_count  (cmd_count),
    .wr_valid   (wr_valid),
    .wr_idx     (wr_idx),
    .func_err   (func_err),
    .len_err    (len_err),
    .crc_err    (crc_err)
);

// File: tb/test_rtu_cmd_parser.sv
`timescale 1ns/1ps
module test_rtu_cmd_parser;

    localparam int MAXW = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  my_addr = 8'h01;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        frame_end = 1'b0;
    logic        addr_match, cmd_valid, wr_valid, func_err, len_err, crc_err;
    logic [7:0]  cmd_slave, cmd_func;
    logic [15:0] cmd_start, cmd_count, wr_data;
    logic [4:0]  wr_idx;

    always #5 clk = ~clk;

    rtu_cmd_parser #(.MAX_WORDS(MAXW)) i_rtu_cmd_parser (
        .clk(clk), .rst_n(rst_n), .my_addr(my_addr), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .frame_end(frame_end), .addr_match(addr_match),
        .cmd_valid(cmd_valid), .cmd_slave(cmd_slave), .cmd_func(cmd_func),
        .cmd_start(cmd_start), .cmd_count(cmd_count), .wr_valid(wr_valid),
        .wr_data(wr_data), .wr_idx(wr_idx), .func_err(func_err),
        .len_err(len_err), .crc_err(crc_err)
    );

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    logic [7:0]  fr [0:79];
    int          flen;
    logic [15:0] wexp [0:39];
    int          nwexp;

    // observations during one frame
    int          n_cv, n_ce, n_le, n_fe, n_wr;
    logic [15:0] got_w [0:39];
    int          got_i [0:39];
    logic [7:0]  cv_slave, cv_func;
    logic [15:0] cv_start, cv_count;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_of(input int n);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ {8'h00, fr[i]};
            for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
        end
        return c;
    endfunction

    task automatic sample();
        if (wr_valid) begin
            if (n_wr < 40) begin
                got_w[n_wr] = wr_data;
                got_i[n_wr] = int'(wr_idx);
            end
            n_wr++;
        end
        if (cmd_valid) begin
            n_cv++;
            cv_slave = cmd_slave; cv_func = cmd_func;
            cv_start = cmd_start; cv_count = cmd_count;
        end
        if (crc_err)  n_ce++;
        if (len_err)  n_le++;
        if (func_err) n_fe++;
    endtask

    task automatic send_byte(input logic [7:0] b);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
        sample();
    endtask

    task automatic idle();
        @(negedge clk);
        sample();
    endtask

    task automatic strobe_end();
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        sample();
    endtask

    // builds the frame into fr[], expected words into wexp[]
    task automatic build(input logic [7:0] a, input logic [7:0] f, input logic [15:0] st,
                         input logic [15:0] cnt, input logic [7:0] bc, input bit bad_crc);
        logic [15:0] c;
        flen = 0; nwexp = 0;
        fr[flen++] = a;
        fr[flen++] = f;
        if (f == 8'h03 || f == 8'h06 || f == 8'h10) begin
            fr[flen++] = st[15:8];
            fr[flen++] = st[7:0];
            if (f == 8'h06) begin
                wexp[0] = 16'($urandom);
                nwexp = 1;
                fr[flen++] = wexp[0][15:8];
                fr[flen++] = wexp[0][7:0];
            end else begin
                fr[flen++] = cnt[15:8];
                fr[flen++] = cnt[7:0];
                if (f == 8'h10) begin
                    fr[flen++] = bc;
                    for (int k = 0; k < int'(bc) / 2 && k < 35; k++) begin
                        wexp[k] = 16'($urandom);
                        fr[flen++] = wexp[k][15:8];
                        fr[flen++] = wexp[k][7:0];
                    end
                    nwexp = int'(cnt);
                end
            end
        end else begin
            fr[flen++] = 8'($urandom);
            fr[flen++] = 8'($urandom);
        end
        c = crc_of(flen);
        if (bad_crc) c = c ^ 16'h0100;
        fr[flen++] = c[7:0];
        fr[flen++] = c[15:8];
    endtask

    // 0 none, 1 func_err, 2 len_err, 3 ok, 4 crc_err
    function automatic int expect_kind(input logic [7:0] a, input logic [7:0] f,
                                       input logic [15:0] cnt, input logic [7:0] bc,
                                       input bit bad_crc);
        if (a != my_addr) return 0;
        if (!(f == 8'h03 || f == 8'h06 || f == 8'h10)) return 1;
        if (f != 8'h06 && cnt == 16'd0) return 2;
        if (f == 8'h10 && cnt > 16'(MAXW)) return 2;
        if (f == 8'h10 && {cnt, 1'b0} != {9'd0, bc}) return 2;
        return bad_crc ? 4 : 3;
    endfunction

    task automatic run_frame(input logic [7:0] a, input logic [7:0] f, input logic [15:0] st,
                             input logic [15:0] cnt, input logic [7:0] bc, input bit bad_crc,
                             input int extra, input bit gaps);
        int kind;
        int exp_nw;
        bit am_first;
        build(a, f, st, cnt, bc, bad_crc);
        kind = expect_kind(a, f, cnt, bc, bad_crc);
        exp_nw = (kind >= 3) ? ((f == 8'h06) ? 1 : nwexp) : 0;
        n_cv = 0; n_ce = 0; n_le = 0; n_fe = 0; n_wr = 0;
        am_first = 0;
        for (int i = 0; i < flen; i++) begin
            send_byte(fr[i]);
            if (i == 0) am_first = addr_match;
            if (gaps && ($urandom_range(0, 3) == 0)) idle();
        end
        for (int i = 0; i < extra; i++) send_byte(8'($urandom));
        chk(am_first == (a == my_addr), "R2", "addr_match after address byte",
            int'(am_first), int'(a == my_addr));
        chk(n_fe == (kind == 1 ? 1 : 0), "R3", "func_err pulses", n_fe, kind == 1 ? 1 : 0);
        chk(n_le == (kind == 2 ? 1 : 0), "R6", "len_err pulses", n_le, kind == 2 ? 1 : 0);
        chk(n_cv == (kind == 3 ? 1 : 0), "R7", "cmd_valid pulses", n_cv, kind == 3 ? 1 : 0);
        chk(n_ce == (kind == 4 ? 1 : 0), "R7", "crc_err pulses", n_ce, kind == 4 ? 1 : 0);
        chk(n_wr == exp_nw, "R5", "write word count", n_wr, exp_nw);
        for (int k = 0; k < exp_nw && k < n_wr && k < 40; k++) begin
            chk(got_w[k] == wexp[k], "R5", "write word data", int'(got_w[k]), int'(wexp[k]));
            chk(got_i[k] == k, "R5", "write word index", got_i[k], k);
        end
        if (kind == 3 && n_cv == 1) begin
            chk(cv_slave == a, "R4", "cmd_slave", int'(cv_slave), int'(a));
            chk(cv_func == f, "R4", "cmd_func", int'(cv_func), int'(f));
            chk(cv_start == st, "R4", "cmd_start", int'(cv_start), int'(st));
            chk(cv_count == ((f == 8'h06) ? 16'd1 : cnt), "R4", "cmd_count",
                int'(cv_count), (f == 8'h06) ? 1 : int'(cnt));
        end
        strobe_end();
        chk(!addr_match, "R8", "addr_match after frame_end", int'(addr_match), 0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            fails++; tests++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!(addr_match || cmd_valid || wr_valid || func_err || len_err || crc_err),
            "R1", "outputs in reset", 1, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!(addr_match || cmd_valid || wr_valid || func_err || len_err || crc_err),
            "R1", "outputs after reset", 1, 0);

        // directed corner cases
        run_frame(8'h01, 8'h03, 16'h1000, 16'h0002, 8'h00, 0, 0, 0); // R4 read
        run_frame(8'h01, 8'h06, 16'h1001, 16'h0000, 8'h00, 0, 0, 0); // R5 single write
        run_frame(8'h01, 8'h10, 16'h1070, 16'h0002, 8'h04, 0, 0, 0); // R5 multi write
        run_frame(8'h01, 8'h10, 16'h0000, 16'd32,   8'd64, 0, 0, 0); // R6 boundary ok
        run_frame(8'h01, 8'h10, 16'h0000, 16'd33,   8'd66, 0, 0, 0); // R6 too many
        run_frame(8'h01, 8'h10, 16'h0000, 16'd0,    8'd0,  0, 0, 0); // R6 zero write
        run_frame(8'h01, 8'h03, 16'h0000, 16'd0,    8'd0,  0, 0, 0); // R6 zero read
        run_frame(8'h01, 8'h10, 16'h0005, 16'd3,    8'd8,  0, 0, 0); // R6 byte count
        run_frame(8'h01, 8'h03, 16'h0020, 16'd4,    8'd0,  1, 0, 0); // R7 bad CRC
        run_frame(8'h01, 8'h04, 16'h0000, 16'd0,    8'd0,  0, 0, 0); // R3 unknown code
        run_frame(8'h07, 8'h03, 16'h0000, 16'd1,    8'd0,  0, 0, 0); // R2 other slave
        run_frame(8'h01, 8'h06, 16'h00AA, 16'd0,    8'd0,  0, 3, 0); // R8 trailing bytes

        // R8: truncated frame then a clean one
        n_cv = 0; n_ce = 0; n_le = 0; n_fe = 0; n_wr = 0;
        send_byte(8'h01); send_byte(8'h03); send_byte(8'h00); send_byte(8'h10);
        send_byte(8'h00);
        strobe_end();
        chk((n_cv + n_ce + n_le + n_fe + n_wr) == 0, "R8", "pulses from truncated frame",
            n_cv + n_ce + n_le + n_fe + n_wr, 0);
        run_frame(8'h01, 8'h03, 16'h0010, 16'd2, 8'd0, 0, 0, 0);

        // R8: frame_end wins over a byte in the same cycle
        frame_end = 1'b1; rx_valid = 1'b1; rx_byte = 8'h01;
        @(negedge clk);
        frame_end = 1'b0; rx_valid = 1'b0;
        chk(!addr_match, "R8", "byte with frame_end ignored", int'(addr_match), 0);

        // constrained random frames
        for (int t = 0; t < 150; t++) begin
            logic [7:0]  a, f, bc;
            logic [15:0] st, cnt;
            bit          bad;
            int          r;
            a  = ($urandom_range(0, 7) == 0) ? (my_addr ^ 8'(1 + $urandom_range(0, 254)))
                                             : my_addr;
            r  = $urandom_range(0, 9);
            f  = (r < 3) ? 8'h03 : (r < 6) ? 8'h06 : (r < 9) ? 8'h10 : 8'h2B;
            st = 16'($urandom);
            if (f == 8'h03) cnt = ($urandom_range(0, 7) == 0) ? 16'd0 : 16'($urandom_range(1, 125));
            else if (f == 8'h10) cnt = ($urandom_range(0, 9) == 0) ? 16'($urandom_range(33, 34))
                                   : ($urandom_range(0, 9) == 0) ? 16'd0
                                   : 16'($urandom_range(1, 32));
            else cnt = 16'd0;
            bc  = 8'(2 * cnt);
            if ($urandom_range(0, 9) == 0) bc = bc + 8'd2;
            bad = ($urandom_range(0, 5) == 0);
            run_frame(a, f, st, cnt, bc, bad, $urandom_range(0, 1), 1);
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule